// File: doc/BRIEF.md
# Multilevel Prioritized Interrupt Controller

This block sits between a set of peripheral interrupt sources and a CPU. Every source owns a sticky pending flag that is set by a one-cycle event pulse. It also has an enable bit, an auto-clear option and a two-bit priority level. The controller picks one winner among the sources that may be served. It drives a single request with a vector number, and it tracks which priority levels the CPU is currently serving.

The CPU answers a request with an acknowledge pulse. The acknowledge marks the winner's level as in service and, for auto-clear sources, drops the winner's flag. A separate return strobe ends service of the highest active level. Software clears flags by writing ones. The request is held off by a global enable, per-level enables, a lock input, and a four-cycle guard window that follows a protected-register signature write.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A source event pulse sets that source's flag whatever its enable, its level enable, the global enable or the lock. The flag then stays set until it is cleared, and it raises a request once all gates open.
- R2: When `clr_we` is high, each one in `clr_bits` clears the matching flag and each zero leaves its flag alone. If an event and a clear hit the same flag in the same cycle, the flag ends set.
- R3: An accepted acknowledge (`irq_ack` high while `irq_req` is high) clears the winning flag only if that source's `src_autoclr` bit is one. Otherwise the flag stays set until software clears it.
- R4: Source i's level is `src_lvl[2i+1:2i]`, where 0 is low, 1 is medium, and 2 or 3 is high. The winner is the eligible source with the highest level, and ties go to the lowest index. `irq_vec` is the winner's index plus one, and it is 0 whenever `irq_req` is low.
- R5: A source is eligible only if its flag, its `src_en` bit and the enable of its level are all set. The level enables are `lvl_en[0]` low, `lvl_en[1]` medium and `lvl_en[2]` high. `irq_req` also needs `gie` high.
- R6: While levels are in service, only a source whose level is strictly above the highest in-service level is eligible.
- R7: `in_service[0]`, `[1]` and `[2]` flag low, medium and high level in service. An accepted acknowledge sets the winner's level bit. A `reti` pulse clears only the highest set bit, and nothing else clears these bits.
- R8: While `lock` is high, `irq_req` is low.
- R9: A `sig_write` pulse keeps `irq_req` low in each of the four cycles after the clock edge that samples it.
- R10: An acknowledge while `irq_req` is low changes no flag and no in-service bit.
- R11: After reset all flags and in-service bits are zero, `irq_req` is low and `irq_vec` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | NSRC | Per-source event pulses |
| src_en | input | NSRC | Per-source enables |
| src_lvl | input | 2*NSRC | Per-source level codes |
| src_autoclr | input | NSRC | Per-source clear-on-acknowledge option |
| lvl_en | input | 3 | Level enables (low, medium, high) |
| gie | input | 1 | Global interrupt enable |
| lock | input | 1 | Blocks all requests |
| sig_write | input | 1 | Correct protection signature written (pulse) |
| clr_we | input | 1 | Flag clear strobe |
| clr_bits | input | NSRC | Write-one-to-clear mask |
| irq_ack | input | 1 | CPU takes the vector |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Request to CPU |
| irq_vec | output | $clog2(NSRC+1) | Vector number, 0 when idle |
| in_service | output | 3 | Per-level in-service status |

## Verification
Three pairs of events can land in the same cycle. A software clear can meet a fresh event on the same flag. An acknowledge can meet a return strobe, so one level bit is set while the highest old one is cleared. An acknowledge can also meet a software clear of the winner. The random phase fires events, clears, acknowledges and returns on the same cycles often. A bench model folds each cycle's inputs into next-state flags and status in a fixed order, and it compares the request, the vector and the status every cycle. Directed cases force the event-versus-clear and acknowledge-with-return collisions and check the exact surviving flag and in-service bits.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int LVLS = 3;
  typedef logic [1:0] rank_t;  // 0 = none, 1 low, 2 medium, 3 high

  function automatic rank_t code_to_rank(input logic [1:0] code);
    if (code >= 2'd2) return 2'd3;
    return 2'(code + 2'd1);
  endfunction

  function automatic rank_t top_rank(input logic [LVLS-1:0] svc);
    if (svc[2]) return 2'd3;
    if (svc[1]) return 2'd2;
    if (svc[0]) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [LVLS-1:0] rank_bit(input rank_t r);
    logic [LVLS-1:0] b;
    b = '0;
    if (r != 2'd0) b[r - 2'd1] = 1'b1;
    return b;
  endfunction
endpackage

// File: rtl/prio_irq_flags.sv
module prio_irq_flags #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] sw_clr,
  input  logic [NSRC-1:0] ack_clr,
  output logic [NSRC-1:0] flags
);
  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~sw_clr & ~ack_clr) | evt;
  end
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
  import prio_irq_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]   flags,
  input  logic [NSRC-1:0]   src_en,
  input  logic [2*NSRC-1:0] src_lvl,
  input  logic [LVLS-1:0]   lvl_en,
  input  rank_t             svc_top,
  output logic              any_elig,
  output logic [IW-1:0]     win_idx,
  output rank_t             win_rank
);
  rank_t           rank [NSRC];
  logic [NSRC-1:0] elig;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign rank[i] = code_to_rank(src_lvl[2*i +: 2]);
    assign elig[i] = flags[i] && src_en[i] && lvl_en[rank[i] - 2'd1]
                     && (rank[i] > svc_top);
  end

  always_comb begin
    win_idx  = '0;
    win_rank = 2'd0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i] && rank[i] >= win_rank) begin
        win_idx  = IW'(i);
        win_rank = rank[i];
      end
    end
  end

  assign any_elig = |elig;
endmodule

// File: rtl/prio_irq_svc.sv
module prio_irq_svc
  import prio_irq_pkg::*;
#(
  parameter int HOLD = 4,
  localparam int CW = $clog2(HOLD + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  rank_t           take_rank,
  input  logic            reti,
  input  logic            sig_write,
  output logic [LVLS-1:0] in_service,
  output rank_t           svc_top,
  output logic            holdoff
);
  logic [CW-1:0]   hold_cnt;
  logic [LVLS-1:0] svc_next;

  assign svc_top = top_rank(in_service);
  assign holdoff = (hold_cnt != '0);

  always_comb begin
    svc_next = in_service;
    if (reti) svc_next = svc_next & ~rank_bit(svc_top);
    if (take) svc_next = svc_next | rank_bit(take_rank);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_service <= '0;
      hold_cnt   <= '0;
    end else begin
      in_service <= svc_next;
      if (sig_write)       hold_cnt <= CW'(HOLD);
      else if (holdoff)    hold_cnt <= hold_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int HOLD = 4,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int VW = $clog2(NSRC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_evt,
  input  logic [NSRC-1:0]   src_en,
  input  logic [2*NSRC-1:0] src_lvl,
  input  logic [NSRC-1:0]   src_autoclr,
  input  logic [2:0]        lvl_en,
  input  logic              gie,
  input  logic              lock,
  input  logic              sig_write,
  input  logic              clr_we,
  input  logic [NSRC-1:0]   clr_bits,
  input  logic              irq_ack,
  input  logic              reti,
  output logic              irq_req,
  output logic [VW-1:0]     irq_vec,
  output logic [2:0]        in_service
);
  logic [NSRC-1:0] flags;
  logic [NSRC-1:0] sw_clr;
  logic [NSRC-1:0] ack_clr;
  logic            any_elig;
  logic [IW-1:0]   win_idx;
  rank_t           win_rank;
  rank_t           svc_top;
  logic            holdoff;
  logic            take;

  assign sw_clr = clr_we ? clr_bits : '0;
  assign take   = irq_ack && irq_req;

  for (genvar i = 0; i < NSRC; i++) begin : g_ackclr
    assign ack_clr[i] = take && src_autoclr[i] && (win_idx == IW'(i));
  end

  prio_irq_flags #(.NSRC(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(src_evt), .sw_clr(sw_clr),
    .ack_clr(ack_clr), .flags(flags)
  );

  prio_irq_arb #(.NSRC(NSRC)) u_arb (
    .flags(flags), .src_en(src_en), .src_lvl(src_lvl), .lvl_en(lvl_en),
    .svc_top(svc_top), .any_elig(any_elig), .win_idx(win_idx),
    .win_rank(win_rank)
  );

  prio_irq_svc #(.HOLD(HOLD)) u_svc (
    .clk(clk), .rst_n(rst_n), .take(take), .take_rank(win_rank),
    .reti(reti), .sig_write(sig_write), .in_service(in_service),
    .svc_top(svc_top), .holdoff(holdoff)
  );

  assign irq_req = any_elig && gie && !lock && !holdoff;
  assign irq_vec = irq_req ? VW'(win_idx) + VW'(1) : '0;
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk
  import prio_irq_pkg::*;
#(
  parameter int VW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lock,
  input logic          sig_write,
  input logic          irq_ack,
  input logic          reti,
  input logic          irq_req,
  input logic [VW-1:0] irq_vec,
  input logic [2:0]    in_service,
  input rank_t         win_rank,
  input rank_t         svc_top
);
  // R8
  lock_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> !irq_req);
  // R9
  guard_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sig_write) |-> !irq_req);
  // R4
  idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> irq_vec == '0);
  // R6
  preempt_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> win_rank > svc_top);
  // R10
  stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_req && !reti) |=> $stable(in_service));
  // R7
  reti_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !(irq_ack && irq_req) && in_service != 3'b000) |=>
      $countones(in_service) == $countones($past(in_service)) - 1);
  // R7
  ack_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> in_service != 3'b000);
endmodule

bind prio_irq_ctrl prio_irq_chk #(.VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lock(lock), .sig_write(sig_write),
  .irq_ack(irq_ack), .reti(reti), .irq_req(irq_req), .irq_vec(irq_vec),
  .in_service(in_service), .win_rank(win_rank), .svc_top(svc_top)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  localparam int N  = 8;
  localparam int VW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]   src_evt = '0, src_en = '0, src_autoclr = '0, clr_bits = '0;
  logic [2*N-1:0] src_lvl = '0;
  logic [2:0]     lvl_en = '0;
  logic gie = 1'b0, lock = 1'b0, sig_write = 1'b0, clr_we = 1'b0;
  logic irq_ack = 1'b0, reti = 1'b0;
  logic           irq_req;
  logic [VW-1:0]  irq_vec;
  logic [2:0]     in_service;

  int tests = 0, fails = 0;
  logic [N-1:0] m_flags = '0;
  logic [2:0]   m_svc = '0;
  int           m_hold = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl #(.NSRC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .src_en(src_en),
    .src_lvl(src_lvl), .src_autoclr(src_autoclr), .lvl_en(lvl_en),
    .gie(gie), .lock(lock), .sig_write(sig_write), .clr_we(clr_we),
    .clr_bits(clr_bits), .irq_ack(irq_ack), .reti(reti),
    .irq_req(irq_req), .irq_vec(irq_vec), .in_service(in_service)
  );

  function automatic int lvl_of(int i);
    int c;
    c = int'(src_lvl[2*i +: 2]);
    return (c > 2) ? 2 : c;   // 0 low, 1 med, 2 high
  endfunction

  function automatic int svc_level();  // -1 none
    for (int l = 2; l >= 0; l--) if (m_svc[l]) return l;
    return -1;
  endfunction

  // returns winning source or -1; scan levels top down, index upward
  function automatic int model_win();
    int top;
    top = svc_level();
    for (int l = 2; l >= 0; l--) begin
      if (l <= top || !lvl_en[l]) continue;
      for (int i = 0; i < N; i++)
        if (m_flags[i] && src_en[i] && lvl_of(i) == l) return i;
    end
    return -1;
  endfunction

  function automatic bit model_req();
    return (model_win() >= 0) && gie && !lock && (m_hold == 0);
  endfunction

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int w;
    bit r;
    w = model_win();
    r = model_req();
    chk({tag, " req"}, int'(irq_req), int'(r));
    chk({tag, " vec"}, int'(irq_vec), r ? w + 1 : 0);
    chk({tag, " svc"}, int'(in_service), int'(m_svc));
  endtask

  task automatic model_update();
    int w, top;
    bit take;
    w = model_win();
    take = irq_ack && model_req();
    top = svc_level();
    if (clr_we) m_flags = m_flags & ~clr_bits;
    if (take && src_autoclr[w]) m_flags[w] = 1'b0;
    m_flags = m_flags | src_evt;
    if (reti && top >= 0) m_svc[top] = 1'b0;
    if (take) m_svc[lvl_of(w)] = 1'b1;
    if (sig_write) m_hold = 4;
    else if (m_hold > 0) m_hold--;
  endtask

  // called just after a negedge with inputs set
  task automatic step(string tag);
    #1 compare(tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
    src_evt = '0; clr_we = 1'b0; clr_bits = '0;
    irq_ack = 1'b0; reti = 1'b0; sig_write = 1'b0;
  endtask

  task automatic set_lvl(int i, int code);
    src_lvl[2*i +: 2] = 2'(code);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 req", int'(irq_req), 0);
    chk("R11 vec", int'(irq_vec), 0);
    chk("R11 svc", int'(in_service), 0);

    // R1 flag latches while disabled
    src_evt[3] = 1'b1; set_lvl(3, 0); step("R1 evt disabled");
    step("R1 hold");
    chk("R1 no req yet", int'(irq_req), 0);
    src_en = 8'hFF; lvl_en = 3'b111; gie = 1'b1; src_autoclr = 8'hFF;
    #1 chk("R1 req after enable", int'(irq_req), 1);
    chk("R5 vec src3", int'(irq_vec), 4);
    step("R1 enabled");

    // R5 gating by level enable and global enable
    lvl_en = 3'b110; step("R5 low level off");
    lvl_en = 3'b111; gie = 1'b0; step("R5 gie off");
    gie = 1'b1;

    // R4 priority: src5 high, src6 high, src3 low
    set_lvl(5, 3); set_lvl(6, 2); src_evt[6] = 1'b1; src_evt[5] = 1'b1;
    step("R4 raise");
    #1 chk("R4 lowest index high", int'(irq_vec), 6);
    step("R4 pick");

    // R3 ack with auto-clear; R7 high bit set
    irq_ack = 1'b1; step("R3 ack src5");
    chk("R7 high in service", int'(in_service), 4);
    chk("R6 nothing above high", int'(irq_req), 0);
    step("R6 blocked");

    // R7 reti clears top, src6 next
    reti = 1'b1; step("R7 reti");
    #1 chk("R7 src6 next", int'(irq_vec), 7);
    // R3 non-autoclear src6 keeps flag
    src_autoclr[6] = 1'b0; irq_ack = 1'b1; step("R3 ack keep");
    reti = 1'b1; step("R3 flag kept");
    #1 chk("R3 src6 still pending", int'(irq_vec), 7);
    // R2 event and clear same cycle: event wins
    clr_we = 1'b1; clr_bits = 8'h40; src_evt[6] = 1'b1; step("R2 collide");
    #1 chk("R2 event wins", int'(irq_vec), 7);
    clr_we = 1'b1; clr_bits = 8'h40; step("R2 w1c");
    clr_we = 1'b1; clr_bits = 8'h00; step("R2 zero no effect");
    #1 chk("R2 src3 remains", int'(irq_vec), 4);

    // R10 ack while no request
    lock = 1'b1; irq_ack = 1'b1; step("R8 R10 lock ack");
    chk("R10 svc unchanged", int'(in_service), 0);
    lock = 1'b0;

    // R9 guard window
    sig_write = 1'b1; step("R9 sig");
    for (int k = 0; k < 4; k++) begin
      #1 chk("R9 held", int'(irq_req), 0);
      step("R9 window");
    end
    #1 chk("R9 released", int'(irq_req), 1);

    // R6 preemption: take low, then medium preempts, low does not
    irq_ack = 1'b1; step("R6 take low");
    set_lvl(1, 1); src_evt[1] = 1'b1; src_evt[0] = 1'b1; set_lvl(0, 0);
    step("R6 raise");
    #1 chk("R6 medium preempts", int'(irq_vec), 2);
    irq_ack = 1'b1; reti = 1'b1; step("R7 ack with reti");
    chk("R7 swap bits", int'(in_service), 2);
    reti = 1'b1; step("R7 drain");

    // random phase
    for (int c = 0; c < 4000; c++) begin
      src_evt = ($urandom % 4 == 0) ? N'($urandom) & N'($urandom) : '0;
      if ($urandom % 16 == 0) src_en = N'($urandom) | N'($urandom);
      if ($urandom % 16 == 0) src_lvl = (2*N)'($urandom);
      if ($urandom % 32 == 0) src_autoclr = N'($urandom);
      if ($urandom % 16 == 0) lvl_en = 3'($urandom) | 3'b001;
      gie = ($urandom % 8) != 0;
      lock = ($urandom % 16) == 0;
      sig_write = ($urandom % 40) == 0;
      clr_we = ($urandom % 6) == 0;
      clr_bits = N'($urandom);
      irq_ack = ($urandom % 3) == 0;
      reti = ($urandom % 4) == 0;
      step("R4 R5 R6 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule